// File: doc/BRIEF.md
# Serial Shift / Pulse Counter Unit

This block holds one small data register that serves two purposes under program control. In shift mode it moves one place to the left on every instruction cycle and takes the serial input into its lowest bit, so it can receive and send a continuous bit stream. In count mode it becomes a down-counter. It subtracts one for each falling pulse on the serial input that stays low for a minimum number of instruction cycles.

A processor core reaches the register through an exchange port. On an exchange strobe the core's accumulator value is written into the register, and the register's value from before the update is shown on a read port. The same exchange copies the core's carry flag into a clock-control latch. Two configuration bits select the behaviour. One picks shift or count mode. The other enables the serial output in shift mode, and in count mode its value appears directly on that output. The clock output follows the latch: it is a gated cycle pulse in shift mode and a static level in count mode.

For an unbroken serial stream with the default four-bit width, the core must exchange once every four instruction cycles. The instruction decoder, the accumulator and the pad drivers lie outside this block.

Top module: `sio_unit`

## Requirements
- R1: In shift mode (mode bit 0), on each clock with `cyc_stb` high and no exchange, the register becomes its old bits [WIDTH-2:0] with `si` appended as the new bit 0.
- R2: In count mode (mode bit 1), `si` is sampled on `cyc_stb` clocks. A pulse qualifies once one high sample is followed by LOW_MIN consecutive low samples (default 2). The register drops by one on the strobe clock of the LOW_MIN-th low sample. Each pulse counts once, however long it stays low, and a shorter low run does not count.
- R3: A decrement from 0 wraps the register to all ones (15 for the default width).
- R4: In shift mode, `so` equals the register MSB when the output-enable bit is 1, and equals 0 when that bit is 0. Shifting goes on in both cases.
- R5: In count mode, `so` equals the output-enable bit.
- R6: `xchg_q` always shows the register's current value, which is the value before that clock's update. A clock with `cyc_stb` and `xchg_en` both high loads `xchg_acc` into the register and `xchg_carry` into the clock latch. On that clock the exchange takes precedence over both the shift and the count.
- R7: `sk` equals latch AND `cyc_stb` in shift mode, and equals the latch alone in count mode.
- R8: After reset the register is 0, the mode bit and the output-enable bit are both 0, and the latch is 1. As a result `sk` pulses with every `cyc_stb`.
- R9: When `cyc_stb` is low, the register, the latch and the pulse qualifier keep their values, whatever `si`, `xchg_en` or `xchg_acc` do.
- R10: `cfg_wr` loads `cfg_count_mode` into the mode bit and `cfg_so_en` into the output-enable bit on any clock. The new values take effect from the next clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | One-clock strobe marking each instruction cycle |
| si | input | 1 | Serial data or counted pulse input |
| cfg_wr | input | 1 | Loads the two configuration bits |
| cfg_count_mode | input | 1 | 0 selects shift mode, 1 selects count mode |
| cfg_so_en | input | 1 | Serial output enable, or the static `so` level in count mode |
| xchg_en | input | 1 | Exchange request, acted on with `cyc_stb` |
| xchg_acc | input | WIDTH | Accumulator value written by an exchange |
| xchg_carry | input | 1 | Carry copied into the clock latch by an exchange |
| xchg_q | output | WIDTH | Current register value, read by an exchange |
| so | output | 1 | Serial output |
| sk | output | 1 | Clock output |

## Verification
The checker verifies on every cycle the following:
- the one-place shift step;
- that a count step changes the register by zero or minus one, and never while `si` is high;
- the `so` and `sk` selection in both modes;
- the exchange load;
- that the register holds when there is no strobe.

Some behaviour spans several strobes and only the bench's scenarios can show it:
- exactly one decrement for each qualified pulse;
- rejection of a low run that is too short;
- no second count during a long low run;
- the wrap from zero;
- the sync pulse after reset.

Between these, the reference model runs on every clock for directed and pseudo-random stimulus.

// File: rtl/sio_pkg.sv
package sio_pkg;
   typedef enum logic {
      SIO_SHIFT = 1'b0,
      SIO_COUNT = 1'b1
   } sio_mode_e;

   localparam logic SKL_RESET = 1'b1;
endpackage

// File: rtl/sio_cfg.sv
module sio_cfg
   import sio_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cyc_stb,
   input  logic      cfg_wr,
   input  logic      cfg_count_mode,
   input  logic      cfg_so_en,
   input  logic      xchg_en,
   input  logic      xchg_carry,
   output sio_mode_e mode_q,
   output logic      soe_q,
   output logic      skl_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= SIO_SHIFT;
         soe_q  <= 1'b0;
      end else if (cfg_wr) begin
         mode_q <= sio_mode_e'(cfg_count_mode);
         soe_q  <= cfg_so_en;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         skl_q <= SKL_RESET;
      else if (cyc_stb && xchg_en)
         skl_q <= xchg_carry;
   end
endmodule

// File: rtl/sio_qual.sv
module sio_qual #(
   parameter int LOW_MIN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_stb,
   input  logic si,
   output logic fire
);
   logic armed_q;

   generate
      if (LOW_MIN == 1) begin : g_direct
         assign fire = cyc_stb && !si && armed_q;
      end else begin : g_run
         localparam int CW = $clog2(LOW_MIN + 1);
         localparam logic [CW-1:0] LAST = CW'(LOW_MIN - 1);
         localparam logic [CW-1:0] FULL = CW'(LOW_MIN);
         logic [CW-1:0] low_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               low_q <= '0;
            else if (cyc_stb) begin
               if (si)
                  low_q <= '0;
               else if (low_q != FULL)
                  low_q <= low_q + 1'b1;
            end
         end

         assign fire = cyc_stb && !si && armed_q && (low_q == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed_q <= 1'b0;
      else if (cyc_stb) begin
         if (si)
            armed_q <= 1'b1;
         else if (fire)
            armed_q <= 1'b0;
      end
   end
endmodule

// File: rtl/sio_core.sv
module sio_core
   import sio_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_stb,
   input  sio_mode_e        mode,
   input  logic             si,
   input  logic             fire,
   input  logic             xchg_en,
   input  logic [WIDTH-1:0] xchg_acc,
   output logic [WIDTH-1:0] reg_q
);
   logic [WIDTH-1:0] reg_d;

   always_comb begin
      reg_d = reg_q;
      if (xchg_en)
         reg_d = xchg_acc;
      else if (mode == SIO_SHIFT)
         reg_d = {reg_q[WIDTH-2:0], si};
      else if (fire)
         reg_d = reg_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reg_q <= '0;
      else if (cyc_stb)
         reg_q <= reg_d;
   end
endmodule

// File: rtl/sio_outs.sv
module sio_outs
   import sio_pkg::*;
(
   input  sio_mode_e mode,
   input  logic      soe,
   input  logic      skl,
   input  logic      msb,
   input  logic      cyc_stb,
   output logic      so,
   output logic      sk
);
   always_comb begin
      if (mode == SIO_COUNT) begin
         so = soe;
         sk = skl;
      end else begin
         so = soe & msb;
         sk = skl & cyc_stb;
      end
   end
endmodule

// File: rtl/sio_unit.sv
module sio_unit
   import sio_pkg::*;
#(
   parameter int WIDTH   = 4,
   parameter int LOW_MIN = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_stb,
   input  logic             si,
   input  logic             cfg_wr,
   input  logic             cfg_count_mode,
   input  logic             cfg_so_en,
   input  logic             xchg_en,
   input  logic [WIDTH-1:0] xchg_acc,
   input  logic             xchg_carry,
   output logic [WIDTH-1:0] xchg_q,
   output logic             so,
   output logic             sk
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sio_unit: WIDTH must be at least 2");
      end
      if (LOW_MIN < 1) begin : g_bad_low
         $error("sio_unit: LOW_MIN must be at least 1");
      end
   endgenerate

   sio_mode_e mode_q;
   logic      soe_q;
   logic      skl_q;
   logic      fire;

   sio_cfg u_cfg (
      .clk            (clk),
      .rst_n          (rst_n),
      .cyc_stb        (cyc_stb),
      .cfg_wr         (cfg_wr),
      .cfg_count_mode (cfg_count_mode),
      .cfg_so_en      (cfg_so_en),
      .xchg_en        (xchg_en),
      .xchg_carry     (xchg_carry),
      .mode_q         (mode_q),
      .soe_q          (soe_q),
      .skl_q          (skl_q)
   );

   sio_qual #(.LOW_MIN(LOW_MIN)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .cyc_stb (cyc_stb),
      .si      (si),
      .fire    (fire)
   );

   sio_core #(.WIDTH(WIDTH)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .cyc_stb  (cyc_stb),
      .mode     (mode_q),
      .si       (si),
      .fire     (fire),
      .xchg_en  (xchg_en),
      .xchg_acc (xchg_acc),
      .reg_q    (xchg_q)
   );

   sio_outs u_outs (
      .mode    (mode_q),
      .soe     (soe_q),
      .skl     (skl_q),
      .msb     (xchg_q[MSB]),
      .cyc_stb (cyc_stb),
      .so      (so),
      .sk      (sk)
   );
endmodule

// File: rtl/sio_unit_chk.sv
module sio_unit_chk #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cyc_stb,
   input logic             si,
   input logic             xchg_en,
   input logic [WIDTH-1:0] xchg_acc,
   input logic             xchg_carry,
   input logic [WIDTH-1:0] xchg_q,
   input logic             so,
   input logic             sk,
   input logic             mode_q,
   input logic             soe_q,
   input logic             skl_q
);
   assert_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_stb && !mode_q && !xchg_en) |=> xchg_q == {$past(xchg_q[WIDTH-2:0]), $past(si)});

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_stb && mode_q && !xchg_en) |=>
         (xchg_q == $past(xchg_q)) || (xchg_q == WIDTH'($past(xchg_q) - 1'b1)));

   assert_no_count_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_stb && mode_q && !xchg_en && si) |=> $stable(xchg_q));

   assert_so_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> so == (soe_q && xchg_q[WIDTH-1]));

   assert_so_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q |-> so == soe_q);

   assert_xchg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_stb && xchg_en) |=> (xchg_q == $past(xchg_acc)) && (skl_q == $past(xchg_carry)));

   assert_sk_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> sk == (skl_q && cyc_stb));

   assert_sk_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q |-> sk == skl_q);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_stb |=> $stable(xchg_q) && $stable(skl_q));
endmodule

bind sio_unit sio_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cyc_stb    (cyc_stb),
   .si         (si),
   .xchg_en    (xchg_en),
   .xchg_acc   (xchg_acc),
   .xchg_carry (xchg_carry),
   .xchg_q     (xchg_q),
   .so         (so),
   .sk         (sk),
   .mode_q     (mode_q),
   .soe_q      (soe_q),
   .skl_q      (skl_q)
);

// File: tb/sio_unit_bench.sv
module sio_unit_bench;
   localparam int W       = 4;
   localparam int LOW_MIN = 2;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         cyc_stb, si, cfg_wr, cfg_count_mode, cfg_so_en;
   logic         xchg_en, xchg_carry;
   logic [W-1:0] xchg_acc;
   logic [W-1:0] xchg_q;
   logic         so, sk;

   int n_vec  = 0;
   int n_fail = 0;

   // behavioural reference state
   int m_reg, m_mode, m_soe, m_skl, m_armed, m_low;

   always #4 clk = ~clk;

   sio_unit #(.WIDTH(W), .LOW_MIN(LOW_MIN)) u_sio_unit (
      .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .si(si),
      .cfg_wr(cfg_wr), .cfg_count_mode(cfg_count_mode), .cfg_so_en(cfg_so_en),
      .xchg_en(xchg_en), .xchg_acc(xchg_acc), .xchg_carry(xchg_carry),
      .xchg_q(xchg_q), .so(so), .sk(sk)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int exp_so();
      if (m_mode == 1) return m_soe;
      return (m_soe == 1) ? ((m_reg >> (W - 1)) & 1) : 0;
   endfunction

   function automatic int exp_sk();
      if (m_mode == 1) return m_skl;
      return m_skl & int'(cyc_stb);
   endfunction

   // one clock: drive at negedge, compare, then advance the model at posedge
   task automatic step(input bit stb, input bit s, input bit xc, input int acc,
                       input bit cr, input bit cw, input bit cm, input bit cs);
      int  nreg;
      bit  fire;
      @(negedge clk);
      cyc_stb = stb; si = s; xchg_en = xc; xchg_acc = W'(acc); xchg_carry = cr;
      cfg_wr = cw; cfg_count_mode = cm; cfg_so_en = cs;
      #1;
      check(int'(xchg_q) == m_reg, (m_mode == 1) ? "R2 register" : "R1 register",
            int'(xchg_q), m_reg);
      check(int'(so) == exp_so(), (m_mode == 1) ? "R5 so" : "R4 so", int'(so), exp_so());
      check(int'(sk) == exp_sk(), "R7 sk", int'(sk), exp_sk());
      @(posedge clk);
      fire = 1'b0;
      nreg = m_reg;
      if (stb) begin
         if (s) begin
            m_armed = 1; m_low = 0;
         end else if (m_low < LOW_MIN) begin
            m_low++;
            if (m_low == LOW_MIN && m_armed == 1) begin
               fire = 1'b1; m_armed = 0;
            end
         end
         if (xc) begin
            nreg = acc % (1 << W); m_skl = int'(cr);
         end else if (m_mode == 0)
            nreg = ((m_reg << 1) | int'(s)) % (1 << W);
         else if (fire)
            nreg = (m_reg + (1 << W) - 1) % (1 << W);
      end
      m_reg = nreg;
      if (cw) begin
         m_mode = int'(cm); m_soe = int'(cs);
      end
   endtask

   task automatic idle(input int n, input bit s);
      for (int i = 0; i < n; i++) step(1'b0, s, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic cyc(input bit s);
      step(1'b1, s, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic xchg(input int acc, input bit cr);
      step(1'b1, 1'b1, 1'b1, acc, cr, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic cfg(input bit cm, input bit cs);
      step(1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b1, cm, cs);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      bit [7:0] lfsr;
      rst_n = 1'b0; cyc_stb = 1'b0; si = 1'b0; cfg_wr = 1'b0; cfg_count_mode = 1'b0;
      cfg_so_en = 1'b0; xchg_en = 1'b0; xchg_acc = '0; xchg_carry = 1'b0;
      m_reg = 0; m_mode = 0; m_soe = 0; m_skl = 1; m_armed = 0; m_low = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R8: reset state, sk pulses with the strobe
      @(negedge clk); cyc_stb = 1'b1; #1;
      check(xchg_q == '0, "R8 reset register", int'(xchg_q), 0);
      check(sk == 1'b1, "R8 sk sync pulse", int'(sk), 1);
      check(so == 1'b0, "R8 so idle", int'(so), 0);
      @(negedge clk); cyc_stb = 1'b0; #1;
      check(sk == 1'b0, "R8 sk low between strobes", int'(sk), 0);

      // R1/R4: shift with so disabled, then enabled
      cyc(1); cyc(0); cyc(1); cyc(1); idle(2, 0); cyc(0);
      cfg(0, 1);
      cyc(1); cyc(0); cyc(0); cyc(1); cyc(1);

      // R9: no strobe, si and exchange request wiggle
      step(1'b0, 1'b0, 1'b1, 9, 1'b0, 1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b1, 6, 1'b0, 1'b0, 1'b0, 1'b0);
      #2 check(int'(xchg_q) == m_reg, "R9 hold without strobe", int'(xchg_q), m_reg);

      // R6/R7: exchange with carry 0 suppresses sk, then carry 1 restores it
      xchg(4'hA, 1'b0); cyc(0); cyc(1);
      xchg(4'h5, 1'b1); cyc(1);

      // R10 + R5: counter mode, so follows enable bit
      cfg(1, 1); cyc(1);
      cfg(1, 0); cyc(1);
      #2 check(so == 1'b0, "R10 R5 so follows enable", int'(so), 0);

      // R2/R3: load 2, count three qualified pulses -> wraps to 15
      xchg(2, 1'b1);
      for (int p = 0; p < 3; p++) begin
         cyc(1); cyc(0); idle(1, 0); cyc(0);
      end
      #2 check(int'(xchg_q) == 15, "R3 wrap from zero", int'(xchg_q), 15);
      // R2: short low run ignored, long low run counted once
      cyc(1); cyc(0); cyc(1);
      cyc(1); for (int i = 0; i < 6; i++) cyc(0);
      #2 check(int'(xchg_q) == 14, "R2 one count per pulse", int'(xchg_q), 14);
      // R6: exchange wins over a firing count
      cyc(1); cyc(0);
      step(1'b1, 1'b0, 1'b1, 7, 1'b0, 1'b0, 1'b0, 1'b0);
      #2 check(int'(xchg_q) == 7, "R6 exchange precedence", int'(xchg_q), 7);

      // mixed pseudo-random traffic against the model
      lfsr = 8'h5B;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         step(lfsr[0] | lfsr[1], lfsr[2], lfsr[3] & lfsr[4] & lfsr[5],
              int'(lfsr[7:4]), lfsr[6], (lfsr == 8'h3C) | (i % 97 == 0),
              lfsr[1], lfsr[7]);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule